// File: doc/BRIEF.md
# Five-Port Mesh Packet Router

This block is a single node of a two-dimensional mesh. Four ports face the neighbouring nodes (north, south, east, west) and one faces the local processor. Every port has a 32-bit input link and a 32-bit output link, each travelling in one direction. Flow control uses credits, so no word is ever dropped. A sender holds back whenever it has no credit left.

A packet starts with a header word. The header gives the destination column and row and the number of payload words that follow. Each input buffers its words in a small FIFO. The node routes each header on the column first and then on the row. The header then competes round-robin for its output. Once a header wins an output, that output stays attached to the same input until the stated number of payload words has passed. The node's own column and row are fixed when the block is instantiated.

Top module: `mesh_router`

## Requirements
- R1: While reset is held and in the first cycle after release, every `out_valid_o` and `in_credit_o` bit is low.
- R2: A header word holds the destination column in bits 3:0, the destination row in bits 7:4 and the payload length (0 to 128 words) in bits 15:8. Bits 31:16 pass through unchanged. Every word leaves the router exactly as it entered.
- R3: The router compares the destination column with `NODE_X` first. A greater column goes out on port 3 (east). A smaller column goes out on port 4 (west).
- R4: When the column matches, the router compares the row with `NODE_Y`. A greater row goes to port 1 (north) and a smaller row goes to port 2 (south). When both coordinates match, the packet goes to port 0 (local).
- R5: After a header leaves on an output, the next words on that output are the payload of that same packet, in their original order, with no other word interleaved.
- R6: An output is released when the number of payload words given in the header has passed. A zero-length header releases the output at once, and the next header may take it.
- R7: When several inputs request a free output in the same cycle, the grants rotate round-robin. Two inputs that keep requesting the same output are served alternately.
- R8: Each output keeps a credit count. The count starts at the FIFO depth, falls by one for each word sent and rises by one for each `out_credit_i` pulse. An output with no credit sends nothing, so at most FIFO-depth words are ever unacknowledged.
- R9: Each word taken from an input FIFO gives exactly one pulse on that input's `in_credit_o`. No accepted word is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 5x32 | Incoming word per port (0 local, 1 north, 2 south, 3 east, 4 west) |
| in_valid_i | input | 5 | Incoming word valid, per port |
| in_credit_o | output | 5 | One-cycle pulse per word freed in that input FIFO |
| out_data_o | output | 5x32 | Outgoing word per port |
| out_valid_o | output | 5 | Outgoing word valid, per port |
| out_credit_i | input | 5 | Credit returned by the downstream receiver, one per word |

## Verification
The hardest case to reach is a long packet that holds an output while another input's header waits for the same output and the downstream side withholds credits. In that case the lock, the credit stall and the arbitration all interact. The bench reaches it with directed cases. In one, the local sink stops returning credit in the middle of a packet, and the bench checks that the sender stalls with exactly one FIFO of words in flight. In another, two inputs load back-to-back zero-length headers toward the same output in the same cycle, so that the grant order shows the rotation. A seeded random phase then sends mixed-length packets to random destinations, with irregular injection and credit return.

// File: rtl/router_pkg.sv
package router_pkg;
  localparam int NPORTS  = 5;
  localparam int PORT_W  = 3;
  localparam int COORD_W = 4;
  localparam int LEN_W   = 8;
  localparam int X_LSB   = 0;
  localparam int Y_LSB   = 4;
  localparam int LEN_LSB = 8;

  typedef enum logic [PORT_W-1:0] {
    PORT_LOCAL = 3'd0,
    PORT_NORTH = 3'd1,
    PORT_SOUTH = 3'd2,
    PORT_EAST  = 3'd3,
    PORT_WEST  = 3'd4
  } port_e;

  // column first, then row
  function automatic port_e route_port(input logic [COORD_W-1:0] dst_x,
                                       input logic [COORD_W-1:0] dst_y,
                                       input logic [COORD_W-1:0] here_x,
                                       input logic [COORD_W-1:0] here_y);
    if (dst_x > here_x) return PORT_EAST;
    if (dst_x < here_x) return PORT_WEST;
    if (dst_y > here_y) return PORT_NORTH;
    if (dst_y < here_y) return PORT_SOUTH;
    return PORT_LOCAL;
  endfunction
endpackage

// File: rtl/router_fifo.sv
module router_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW:0]   wr_q, rd_q;

  assign empty_o = (wr_q == rd_q);
  assign full_o  = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
  assign data_o  = mem_q[rd_q[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q[AW-1:0]] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_q + 1'b1;
      if (pop_i)  rd_q <= rd_q + 1'b1;
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R9
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/router_rr_arb.sv
module router_rr_arb #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         adv_i,
  output logic [N-1:0] gnt_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q;
  logic [IW-1:0] win_idx;
  logic          found;

  always_comb begin
    gnt_o   = '0;
    found   = 1'b0;
    win_idx = '0;
    for (int k = 0; k < N; k++) begin
      int unsigned idx;
      idx = (int'(ptr_q) + k) % N;
      if (!found && req_i[idx]) begin
        gnt_o[idx] = 1'b1;
        found      = 1'b1;
        win_idx    = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (adv_i && found)
      ptr_q <= (int'(win_idx) == N-1) ? '0 : win_idx + 1'b1;
  end

  // R7
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  // R7
  gnt_in_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
endmodule

// File: rtl/router_out_port.sv
module router_out_port
  import router_pkg::*;
#(
  parameter int NP    = 5,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NP-1:0]          req_i,
  input  logic [NP-1:0][DW-1:0]  head_i,
  input  logic [NP-1:0]          avail_i,
  input  logic                   credit_i,
  output logic [NP-1:0]          pop_o,
  output logic                   locked_o,
  output logic [$clog2(NP)-1:0]  owner_o,
  output logic [DW-1:0]          data_o,
  output logic                   valid_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(NP);

  logic [CW-1:0]    credit_q;
  logic             locked_q;
  logic [IW-1:0]    owner_q;
  logic [LEN_W-1:0] rem_q;

  logic             can_send, arb_adv, send;
  logic [NP-1:0]    arb_req, gnt;
  logic [IW-1:0]    gnt_idx, sel;
  logic [DW-1:0]    word;
  logic [LEN_W-1:0] hdr_len;

  assign can_send = (credit_q != '0);
  assign arb_adv  = !locked_q && can_send;
  assign arb_req  = req_i & {NP{arb_adv}};

  router_rr_arb #(.N(NP)) arb_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (arb_req),
    .adv_i  (arb_adv),
    .gnt_o  (gnt)
  );

  always_comb begin
    gnt_idx = '0;
    for (int k = 0; k < NP; k++)
      if (gnt[k]) gnt_idx = IW'(k);
  end

  always_comb begin
    send  = 1'b0;
    pop_o = '0;
    sel   = owner_q;
    if (locked_q) begin
      send = avail_i[owner_q] && can_send;
      if (send) pop_o[owner_q] = 1'b1;
    end else begin
      send  = |gnt;
      pop_o = gnt;
      sel   = gnt_idx;
    end
  end

  assign word    = head_i[sel];
  assign hdr_len = word[LEN_LSB +: LEN_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      credit_q <= CW'(DEPTH);
      locked_q <= 1'b0;
      owner_q  <= '0;
      rem_q    <= '0;
      valid_o  <= 1'b0;
      data_o   <= '0;
    end else begin
      credit_q <= credit_q - CW'(send) + CW'(credit_i);
      valid_o  <= send;
      if (send) data_o <= word;
      if (!locked_q && send && hdr_len != '0) begin
        locked_q <= 1'b1;
        owner_q  <= sel;
        rem_q    <= hdr_len;
      end else if (locked_q && send) begin
        rem_q <= rem_q - 1'b1;
        if (rem_q == LEN_W'(1)) locked_q <= 1'b0;
      end
    end
  end

  assign locked_o = locked_q;
  assign owner_o  = owner_q;

  // R8
  credit_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    credit_q <= CW'(DEPTH));
  // R8
  send_needs_credit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(credit_q) != '0);
  // R5
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_q && !(send && rem_q == LEN_W'(1))) |=> (locked_q && $stable(owner_q)));
  // R6
  lock_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_q && send && rem_q == LEN_W'(1)) |=> !locked_q);
endmodule

// File: rtl/mesh_router.sv
module mesh_router
  import router_pkg::*;
#(
  parameter int                 DW         = 32,
  parameter int                 FIFO_DEPTH = 4,
  parameter logic [COORD_W-1:0] NODE_X     = 4'd0,
  parameter logic [COORD_W-1:0] NODE_Y     = 4'd0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NPORTS-1:0][DW-1:0] in_data_i,
  input  logic [NPORTS-1:0]         in_valid_i,
  output logic [NPORTS-1:0]         in_credit_o,
  output logic [NPORTS-1:0][DW-1:0] out_data_o,
  output logic [NPORTS-1:0]         out_valid_o,
  input  logic [NPORTS-1:0]         out_credit_i
);
  localparam int NP = NPORTS;
  localparam int IW = $clog2(NP);

  logic [NP-1:0][DW-1:0] head;
  logic [NP-1:0]         empty, full, avail, active, pop_in;
  port_e                 dir [NP];
  logic [NP-1:0][NP-1:0] req_by_out, pop_by_out, pop_by_in;
  logic [NP-1:0]         locked;
  logic [NP-1:0][IW-1:0] owner;

  for (genvar i = 0; i < NP; i++) begin : g_in
    router_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) fifo_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (in_valid_i[i]),
      .data_i  (in_data_i[i]),
      .pop_i   (pop_in[i]),
      .data_o  (head[i]),
      .empty_o (empty[i]),
      .full_o  (full[i])
    );
    assign avail[i] = !empty[i];
    assign dir[i]   = route_port(head[i][X_LSB +: COORD_W], head[i][Y_LSB +: COORD_W],
                                 NODE_X, NODE_Y);
  end

  // an input is active while some output is locked to it
  always_comb begin
    active = '0;
    for (int o = 0; o < NP; o++)
      if (locked[o]) active[owner[o]] = 1'b1;
  end

  always_comb begin
    for (int o = 0; o < NP; o++)
      for (int i = 0; i < NP; i++) begin
        req_by_out[o][i] = avail[i] && !active[i] && (dir[i] == port_e'(o));
        pop_by_in[i][o]  = pop_by_out[o][i];
      end
    for (int i = 0; i < NP; i++) pop_in[i] = |pop_by_in[i];
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    router_out_port #(.NP(NP), .DW(DW), .DEPTH(FIFO_DEPTH)) port_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (req_by_out[o]),
      .head_i   (head),
      .avail_i  (avail),
      .credit_i (out_credit_i[o]),
      .pop_o    (pop_by_out[o]),
      .locked_o (locked[o]),
      .owner_o  (owner[o]),
      .data_o   (out_data_o[o]),
      .valid_o  (out_valid_o[o])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_credit_o <= '0;
    else         in_credit_o <= pop_in;
  end

  for (genvar i = 0; i < NP; i++) begin : g_chk
    // R5
    single_claim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(pop_by_in[i]));
    // R9
    credit_follows_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pop_in[i] |=> in_credit_o[i]);
  end
endmodule

// File: tb/mesh_router_tb_top.sv
module mesh_router_tb_top;
  localparam int NP = 5;
  localparam int DW = 32;
  localparam int DEPTH = 4;
  localparam logic [3:0] NX = 4'd3;
  localparam logic [3:0] NY = 4'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NP-1:0][DW-1:0] in_data = '0;
  logic [NP-1:0]         in_valid = '0;
  logic [NP-1:0]         in_credit;
  logic [NP-1:0][DW-1:0] out_data;
  logic [NP-1:0]         out_valid;
  logic [NP-1:0]         out_credit = '0;

  mesh_router #(.DW(DW), .FIFO_DEPTH(DEPTH), .NODE_X(NX), .NODE_Y(NY)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .in_data_i    (in_data),
    .in_valid_i   (in_valid),
    .in_credit_o  (in_credit),
    .out_data_o   (out_data),
    .out_valid_o  (out_valid),
    .out_credit_i (out_credit)
  );

  int checks = 0, fails = 0;
  logic [31:0] src_q [NP][$];
  int src_cred [NP];
  int pend [NP], outst [NP], out_words [NP];
  bit sink_en [NP];
  int send_pct = 100, ret_pct = 100;
  int exp_port [1024], exp_len [1024], exp_src [1024], exp_dx [1024];
  bit rx_in [NP];
  int rx_id [NP], rx_len [NP], rx_k [NP];
  int sent_pkts = 0, rcvd_pkts = 0, next_id = 0, cycle = 0;
  bit timeout = 1'b0, log_en = 1'b0;
  int hdr_log [$];

  function automatic int model_port(int dx, int dy);
    if (dx > int'(NX)) return 3;
    if (dx < int'(NX)) return 4;
    if (dy > int'(NY)) return 1;
    if (dy < int'(NY)) return 2;
    return 0;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic add_pkt(int src, int dx, int dy, int len, output int id);
    id = next_id++;
    exp_port[id] = model_port(dx, dy);
    exp_len[id]  = len;
    exp_src[id]  = src;
    exp_dx[id]   = dx;
    src_q[src].push_back({16'(id), 8'(len), 4'(dy), 4'(dx)});
    for (int k = 0; k < len; k++) src_q[src].push_back({16'(id), 16'(k)});
    sent_pkts++;
  endtask

  // per-cycle driver, monitor and sink
  initial begin
    for (int i = 0; i < NP; i++) begin
      src_cred[i] = DEPTH; pend[i] = 0; outst[i] = 0; out_words[i] = 0;
      sink_en[i] = 1'b1; rx_in[i] = 1'b0; rx_id[i] = 0; rx_len[i] = 0; rx_k[i] = 0;
    end
    forever begin
      @(negedge clk);
      if (rst_n) begin
        cycle++;
        if (cycle > 150000) timeout = 1'b1;
        for (int i = 0; i < NP; i++)
          if (in_credit[i]) begin
            src_cred[i]++;
            check(src_cred[i] <= DEPTH, "R9", "sender credit", src_cred[i], DEPTH);
          end
        for (int o = 0; o < NP; o++)
          if (out_valid[o]) begin
            logic [31:0] w;
            w = out_data[o];
            out_words[o]++; outst[o]++; pend[o]++;
            check(outst[o] <= DEPTH, "R8", "unacknowledged words", outst[o], DEPTH);
            if (!rx_in[o]) begin
              int id;
              id = int'(w[31:16]);
              if (exp_dx[id] != int'(NX))
                check(exp_port[id] == o, "R3", "column route port", o, exp_port[id]);
              else
                check(exp_port[id] == o, "R4", "row/local route port", o, exp_port[id]);
              check(int'(w[15:8]) == exp_len[id], "R2", "header length", int'(w[15:8]), exp_len[id]);
              if (o == 0 && log_en) hdr_log.push_back(id);
              rcvd_pkts++;
              if (exp_len[id] > 0) begin
                rx_in[o] = 1'b1; rx_id[o] = id; rx_len[o] = exp_len[id]; rx_k[o] = 0;
              end
            end else begin
              check(w == {16'(rx_id[o]), 16'(rx_k[o])}, "R5", "payload word",
                    int'(w), int'({16'(rx_id[o]), 16'(rx_k[o])}));
              rx_k[o]++;
              if (rx_k[o] == rx_len[o]) rx_in[o] = 1'b0;
            end
          end
        for (int o = 0; o < NP; o++) begin
          out_credit[o] = 1'b0;
          if (pend[o] > 0 && sink_en[o] && ($urandom % 100 < ret_pct)) begin
            out_credit[o] = 1'b1; pend[o]--; outst[o]--;
          end
        end
        for (int i = 0; i < NP; i++) begin
          in_valid[i] = 1'b0;
          if (src_q[i].size() > 0 && src_cred[i] > 0 && ($urandom % 100 < send_pct)) begin
            in_valid[i] = 1'b1;
            in_data[i]  = src_q[i].pop_front();
            src_cred[i]--;
          end
        end
      end
    end
  end

  task automatic drain();
    while (!timeout && rcvd_pkts != sent_pkts) @(negedge clk);
    repeat (20) @(negedge clk);
    for (int o = 0; o < NP; o++)
      check(!rx_in[o], "R6", "packet completed on output", int'(rx_in[o]), 0);
  endtask

  initial begin
    int a1, b1, a2, b2, sid, base0, dummy;
    dummy = $urandom(32'h5EED_0C0F);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == '0, "R1", "out_valid in reset", int'(out_valid), 0);
    check(in_credit == '0, "R1", "in_credit in reset", int'(in_credit), 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(out_valid == '0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(in_credit == '0, "R1", "in_credit after reset", int'(in_credit), 0);

    // R7: two inputs, back-to-back zero-length headers to local
    log_en = 1'b1;
    @(posedge clk);
    add_pkt(1, 3, 3, 0, a1); add_pkt(2, 3, 3, 0, b1);
    add_pkt(1, 3, 3, 0, a2); add_pkt(2, 3, 3, 0, b2);
    drain();
    log_en = 1'b0;
    check(hdr_log.size() == 4, "R7", "local headers seen", hdr_log.size(), 4);
    if (hdr_log.size() == 4) begin
      bit ok;
      ok = (hdr_log[0] == a1 && hdr_log[1] == b1 && hdr_log[2] == a2 && hdr_log[3] == b2) ||
           (hdr_log[0] == b1 && hdr_log[1] == a1 && hdr_log[2] == b2 && hdr_log[3] == a2);
      check(ok, "R7", "alternating grant, first id", hdr_log[0], a1);
    end

    // R8: local sink withholds credit mid-packet
    sink_en[0] = 1'b0;
    base0 = out_words[0];
    @(posedge clk);
    add_pkt(3, 3, 3, 8, sid);
    repeat (40) @(negedge clk);
    check(out_words[0] - base0 == DEPTH, "R8", "words sent without credit return",
          out_words[0] - base0, DEPTH);
    check(src_q[3].size() == 1, "R9", "sender words held back", src_q[3].size(), 1);
    sink_en[0] = 1'b1;
    drain();

    // R5/R6: long packet and a competitor on east; corner directions
    @(posedge clk);
    add_pkt(0, 7, 3, 128, sid);
    add_pkt(4, 9, 0, 5, sid);
    add_pkt(1, 0, 3, 3, sid);
    add_pkt(2, 3, 15, 2, sid);
    add_pkt(3, 3, 0, 0, sid);
    add_pkt(3, 3, 0, 1, sid);
    drain();

    // random traffic
    send_pct = 70; ret_pct = 60;
    @(posedge clk);
    for (int i = 0; i < NP; i++)
      for (int n = 0; n < 40; n++) begin
        int len;
        len = ($urandom % 8 == 0) ? int'($urandom % 40) : int'($urandom % 6);
        add_pkt(i, int'($urandom % 8), int'($urandom % 8), len, sid);
      end
    drain();

    check(rcvd_pkts == sent_pkts, "R9", "packets delivered", rcvd_pkts, sent_pkts);
    for (int i = 0; i < NP; i++)
      check(src_cred[i] == DEPTH, "R9", "sender credits restored", src_cred[i], DEPTH);
    if (timeout) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", rcvd_pkts, sent_pkts);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule